// File: doc/BRIEF.md
# Serial IQ Output Port with Frame Sync

This block serializes one complex sample per output channel, an in-phase word followed by a quadrature word, onto a single-bit data lane. It runs in the serial clock domain and moves one bit per rising edge, most significant bit first. A frame-sync output tells the receiver where the words start. The frame sync has three styles: a single pulse ahead of the frame, a pulse ahead of each word, or a level that covers the whole frame. The word length is 16 or 24 bits and applies to both words. When dual-lane operation is enabled, channel A and channel B leave on lanes 0 and 1 at the same time and share one frame sync.

Each lane has an output enable that stands in for a three-state driver. The enable is high only in the cycles that carry data bits, so several ports can share one receiver input. A user raises `start_i` for one cycle with the sample words and configuration present. The block captures them when the frame begins. A start that arrives while a frame is in flight is remembered, and the next frame follows directly.

The sequencer has four states. `ST_IDLE` waits for a request. `ST_SYNC` is the one-cycle lead-in with no data. `ST_SHIFT_I` shifts the in-phase word and `ST_SHIFT_Q` shifts the quadrature word. The transitions are:
- idle-to-sync, on a start while idle
- sync-to-I, always after one cycle
- I-to-Q, after the I LSB
- Q-to-sync, after the Q LSB when a request is waiting
- Q-to-idle, after the Q LSB when no request is waiting

Top module: `iqs_serial_port`

## Requirements
- R1: After reset, and whenever no frame is in progress, `fs_o`, both `sdo_oe_o` bits and both `sdo_o` bits are 0.
- R2: A start accepted on a rising edge is followed by exactly one lead-in cycle, in which `fs_o`=1 and `sdo_oe_o`=0. The next cycle carries the I MSB. Then the I bits follow MSB first and the Q bits follow MSB first, one bit per cycle with no gap, ending with the Q LSB.
- R3: Word-length bit `cfg_wide_i`=0 selects 16-bit words taken from bits [15:0] of each input word, and the upper bits are ignored. `cfg_wide_i`=1 selects 24-bit words.
- R4: Frame-sync codes 2'b00 and 2'b01 behave the same: `fs_o` is high only in the lead-in cycle.
- R5: Code 2'b10 raises `fs_o` in the lead-in cycle and again in the cycle that carries the I LSB, which is the cycle before the first Q bit. At all other times `fs_o` is low.
- R6: Code 2'b11 holds `fs_o` high from the lead-in cycle through the Q LSB cycle. It is low in the following cycle unless a new frame's lead-in starts there.
- R7: `sdo_oe_o[0]` is high in exactly the 2×W data cycles of each frame, where W is the word length. A lane's `sdo_o` bit is 0 whenever its enable is low.
- R8: With `cfg_dual_i`=1, lane 1 carries channel B (`i_word_i[1]`, `q_word_i[1]`) with the same timing as lane 0, which carries channel A. With `cfg_dual_i`=0, lane 1 stays disabled and 0.
- R9: A start raised during a frame is not lost. The next lead-in cycle follows directly after the Q LSB cycle, and the sample words present at that point are sent.
- R10: Word length, frame-sync code and dual-lane enable are captured at frame start. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send the presented sample pair |
| cfg_wide_i | input | 1 | Word length: 0 = 16 bits, 1 = 24 bits |
| cfg_fs_mode_i | input | 2 | Frame-sync style code |
| cfg_dual_i | input | 1 | Enable lane 1 for channel B |
| i_word_i | input | 2×24 | In-phase word per channel, index 0 = A, 1 = B |
| q_word_i | input | 2×24 | Quadrature word per channel, index 0 = A, 1 = B |
| sdo_o | output | 2 | Serial data per lane |
| sdo_oe_o | output | 2 | Per-lane output enable, high while the lane drives bits |
| fs_o | output | 1 | Frame sync |

## Verification
The hardest situation to reach from the ports is a start that arrives while a frame is in flight. It has to be held, and the configuration inputs change under the running frame at the same moment. The stimulus produces this by issuing the next request a cycle after the current lead-in is seen, with a different word length, frame-sync code and lane setting. The scoreboard then requires that the running frame keeps its original shape. It also requires that the held frame's lead-in arrives one cycle after the previous Q LSB. A chain of three such frames also exercises the Q-to-sync transition twice in a row.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SYNC    = 2'd1,
        ST_SHIFT_I = 2'd2,
        ST_SHIFT_Q = 2'd3
    } iqs_state_e;

    typedef enum logic [1:0] {
        FS_ONCE_A   = 2'b00,
        FS_ONCE_B   = 2'b01,
        FS_PER_WORD = 2'b10,
        FS_ENVELOPE = 2'b11
    } iqs_fs_mode_e;

    typedef struct packed {
        logic         wide;
        iqs_fs_mode_e fs_mode;
        logic         dual;
    } iqs_cfg_t;

endpackage

// File: rtl/iqs_seq.sv
module iqs_seq
    import iqs_pkg::*;
#(
    parameter int MAX_WORD   = 24,
    parameter int SHORT_WORD = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  iqs_cfg_t   cfg_i,
    output iqs_cfg_t   cfg_q_o,
    output iqs_state_e state_o,
    output logic       load_o,
    output logic       shift_o,
    output logic       last_i_o
);

    localparam int CNT_W = $clog2(MAX_WORD);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(MAX_WORD - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_WORD - 1);

    iqs_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, pend_d;
    iqs_cfg_t         cfg_q;
    logic             load;
    logic [CNT_W-1:0] word_last;
    logic             req;

    assign word_last = cfg_q.wide ? LAST_LONG : LAST_SHORT;
    assign req       = start_i | pend_q;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SYNC;
                    load    = 1'b1;
                    pend_d  = 1'b0;
                end
            end
            ST_SYNC: begin
                state_d = ST_SHIFT_I;
                cnt_d   = word_last;
                if (start_i) pend_d = 1'b1;
            end
            ST_SHIFT_I: begin
                if (start_i) pend_d = 1'b1;
                if (cnt_q == '0) begin
                    state_d = ST_SHIFT_Q;
                    cnt_d   = word_last;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_SHIFT_Q: begin
                if (cnt_q == '0) begin
                    if (req) begin
                        state_d = ST_SYNC;
                        load    = 1'b1;
                        pend_d  = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                    if (start_i) pend_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
            if (load) cfg_q <= cfg_i;
        end
    end

    // outputs
    always_comb begin
        shift_o  = (state_q == ST_SHIFT_I) || (state_q == ST_SHIFT_Q);
        last_i_o = (state_q == ST_SHIFT_I) && (cnt_q == '0);
        load_o   = load;
        state_o  = state_q;
        cfg_q_o  = cfg_q;
    end

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHIFT_I) || (state_q == ST_SHIFT_Q)) |-> $stable(cfg_q));

    assert_no_pend_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !pend_q);

    assert_short_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_SHIFT_I) || (state_q == ST_SHIFT_Q)) && !cfg_q.wide) |-> (cnt_q <= LAST_SHORT));

endmodule

// File: rtl/iqs_fs_gen.sv
module iqs_fs_gen
    import iqs_pkg::*;
(
    input  iqs_state_e   state_i,
    input  iqs_fs_mode_e mode_i,
    input  logic         last_i_i,
    output logic         fs_o
);

    logic envelope;
    logic per_word;

    assign envelope = (mode_i == FS_ENVELOPE);
    assign per_word = (mode_i == FS_PER_WORD);

    always_comb begin
        unique case (state_i)
            ST_IDLE:    fs_o = 1'b0;
            ST_SYNC:    fs_o = 1'b1;
            ST_SHIFT_I: fs_o = envelope | (per_word & last_i_i);
            ST_SHIFT_Q: fs_o = envelope;
            default:    fs_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/iqs_lane.sv
module iqs_lane #(
    parameter int MAX_WORD   = 24,
    parameter int SHORT_WORD = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                wide_i,
    input  logic [MAX_WORD-1:0] i_word_i,
    input  logic [MAX_WORD-1:0] q_word_i,
    input  logic                shift_i,
    input  logic                en_i,
    output logic                sdo_o,
    output logic                oe_o
);

    localparam int SR_W  = 2 * MAX_WORD;
    localparam int PAD_W = 2 * (MAX_WORD - SHORT_WORD);

    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] long_img;
    logic [SR_W-1:0] short_img;

    assign long_img = {i_word_i, q_word_i};

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_img = {i_word_i[SHORT_WORD-1:0], q_word_i[SHORT_WORD-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign short_img = long_img;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= wide_i ? long_img : short_img;
        end else if (shift_i) begin
            sr_q <= {sr_q[SR_W-2:0], 1'b0};
        end
    end

    assign sdo_o = en_i ? sr_q[SR_W-1] : 1'b0;
    assign oe_o  = en_i;

    assert_sync_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !oe_o);

endmodule

// File: rtl/iqs_serial_port.sv
module iqs_serial_port
    import iqs_pkg::*;
#(
    parameter int MAX_WORD   = 24,
    parameter int SHORT_WORD = 16,
    parameter int LANES      = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic                           cfg_wide_i,
    input  logic [1:0]                     cfg_fs_mode_i,
    input  logic                           cfg_dual_i,
    input  logic [LANES-1:0][MAX_WORD-1:0] i_word_i,
    input  logic [LANES-1:0][MAX_WORD-1:0] q_word_i,
    output logic [LANES-1:0]               sdo_o,
    output logic [LANES-1:0]               sdo_oe_o,
    output logic                           fs_o
);

    iqs_cfg_t   cfg_in;
    iqs_cfg_t   cfg_q;
    iqs_state_e state;
    logic       load;
    logic       shift;
    logic       last_i;

    assign cfg_in.wide    = cfg_wide_i;
    assign cfg_in.fs_mode = iqs_fs_mode_e'(cfg_fs_mode_i);
    assign cfg_in.dual    = cfg_dual_i;

    iqs_seq #(
        .MAX_WORD   (MAX_WORD),
        .SHORT_WORD (SHORT_WORD)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cfg_i    (cfg_in),
        .cfg_q_o  (cfg_q),
        .state_o  (state),
        .load_o   (load),
        .shift_o  (shift),
        .last_i_o (last_i)
    );

    iqs_fs_gen fs_gen_i (
        .state_i  (state),
        .mode_i   (cfg_q.fs_mode),
        .last_i_i (last_i),
        .fs_o     (fs_o)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic lane_on;
            if (g == 0) begin : g_primary
                assign lane_on = 1'b1;
            end else begin : g_extra
                assign lane_on = cfg_q.dual;
            end
            iqs_lane #(
                .MAX_WORD   (MAX_WORD),
                .SHORT_WORD (SHORT_WORD)
            ) lane_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_i   (load),
                .wide_i   (cfg_in.wide),
                .i_word_i (i_word_i[g]),
                .q_word_i (q_word_i[g]),
                .shift_i  (shift),
                .en_i     (shift & lane_on),
                .sdo_o    (sdo_o[g]),
                .oe_o     (sdo_oe_o[g])
            );
        end
    endgenerate

    assert_envelope_covers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o[0] && (cfg_q.fs_mode == FS_ENVELOPE)) |-> fs_o);

    assert_leadin_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o[0]) |-> ($past(fs_o) && !$past(sdo_oe_o[0])));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o && !cfg_q.fs_mode[1]) |-> !sdo_oe_o[0]);

    assert_lane_pairing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o[LANES-1] |-> sdo_oe_o[0]);

endmodule

// File: tb/iqs_serial_port_tb.sv
`timescale 1ns/1ps
module iqs_serial_port_tb_top;

    typedef struct {
        logic [23:0] ai, aq, bi, bq;
        logic        wide;
        logic [1:0]  mode;
        logic        dual;
        logic        b2b;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             cfg_wide_i = 1'b0;
    logic [1:0]       cfg_fs_mode_i = 2'b00;
    logic             cfg_dual_i = 1'b0;
    logic [1:0][23:0] i_word_i = '0;
    logic [1:0][23:0] q_word_i = '0;
    logic [1:0]       sdo_o;
    logic [1:0]       sdo_oe_o;
    logic             fs_o;

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   last_end = -100;
    bit   in_frame = 0;
    bit   mon_on = 0;
    exp_t q[$];
    exp_t cur;
    int   k, wlen, fs_bad, oe_bad;
    logic [23:0] g0i, g0q, g1i, g1q;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    iqs_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_wide_i(cfg_wide_i), .cfg_fs_mode_i(cfg_fs_mode_i), .cfg_dual_i(cfg_dual_i),
        .i_word_i(i_word_i), .q_word_i(q_word_i),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .fs_o(fs_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // driver: pushes the expected item, pulses start, holds inputs until its lead-in
    task automatic send(input logic [23:0] ai, aq, bi, bq, input logic wide,
                        input logic [1:0] mode, input logic dual, input logic b2b,
                        input string tag);
        exp_t e;
        e.ai = ai; e.aq = aq; e.bi = bi; e.bq = bq;
        e.wide = wide; e.mode = mode; e.dual = dual; e.b2b = b2b; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        i_word_i[0] = ai; q_word_i[0] = aq; i_word_i[1] = bi; q_word_i[1] = bq;
        cfg_wide_i = wide; cfg_fs_mode_i = mode; cfg_dual_i = dual;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!(fs_o && !sdo_oe_o[0])) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (!in_frame) begin
                    if (fs_o) begin
                        chk(sdo_oe_o == 2'b00, "R2", "lead-in enables", 48'(sdo_oe_o), 48'h0);
                        if (q.size() == 0) begin
                            chk(1'b0, "R4", "unexpected frame sync", 48'h1, 48'h0);
                        end else begin
                            cur = q.pop_front();
                            if (cur.b2b)
                                chk(cyc - last_end == 1, "R9", "held start lead-in gap",
                                    48'(cyc - last_end), 48'h1);
                            in_frame = 1; k = 0; fs_bad = 0; oe_bad = 0;
                            wlen = cur.wide ? 24 : 16;
                            g0i = '0; g0q = '0; g1i = '0; g1q = '0;
                        end
                    end else begin
                        chk(sdo_oe_o == 2'b00 && sdo_o == 2'b00, "R1", "idle outputs",
                            48'({sdo_oe_o, sdo_o}), 48'h0);
                    end
                end else begin
                    logic efs;
                    if (cur.mode == 2'b11) efs = 1'b1;
                    else if (cur.mode == 2'b10) efs = (k == wlen - 1);
                    else efs = 1'b0;
                    if (fs_o !== efs) fs_bad++;
                    if (sdo_oe_o[0] !== 1'b1 || sdo_oe_o[1] !== cur.dual) oe_bad++;
                    if (k < wlen) begin
                        g0i = {g0i[22:0], sdo_o[0]}; g1i = {g1i[22:0], sdo_o[1]};
                    end else begin
                        g0q = {g0q[22:0], sdo_o[0]}; g1q = {g1q[22:0], sdo_o[1]};
                    end
                    k++;
                    if (k == 2 * wlen) begin
                        logic [23:0] m;
                        m = cur.wide ? 24'hFFFFFF : 24'h00FFFF;
                        chk(g0i == (cur.ai & m), {"R2 R3 ", cur.tag}, "lane0 I", 48'(g0i), 48'(cur.ai & m));
                        chk(g0q == (cur.aq & m), {"R2 R3 ", cur.tag}, "lane0 Q", 48'(g0q), 48'(cur.aq & m));
                        if (cur.dual) begin
                            chk(g1i == (cur.bi & m), {"R8 ", cur.tag}, "lane1 I", 48'(g1i), 48'(cur.bi & m));
                            chk(g1q == (cur.bq & m), {"R8 ", cur.tag}, "lane1 Q", 48'(g1q), 48'(cur.bq & m));
                        end else begin
                            chk(g1i == 0 && g1q == 0, {"R8 ", cur.tag}, "lane1 quiet",
                                {g1i, g1q}, 48'h0);
                        end
                        chk(fs_bad == 0,
                            cur.mode == 2'b11 ? {"R6 ", cur.tag} :
                            cur.mode == 2'b10 ? {"R5 ", cur.tag} : {"R4 ", cur.tag},
                            "frame sync mismatches", 48'(fs_bad), 48'h0);
                        chk(oe_bad == 0, {"R7 ", cur.tag}, "enable mismatches", 48'(oe_bad), 48'h0);
                        last_end = cyc;
                        in_frame = 0;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fs_o == 0 && sdo_oe_o == 0 && sdo_o == 0, "R1", "reset state",
            48'({fs_o, sdo_oe_o, sdo_o}), 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;
        repeat (3) @(negedge clk);

        // upper bits set in 16-bit frames to show they are ignored (R3)
        send(24'hA5C3_F1, 24'h7E1234, 24'h5B0F0F, 24'hFF8001, 1'b0, 2'b00, 1'b1, 1'b0, "m00");
        repeat (70) @(negedge clk);
        send(24'h123456, 24'h89ABCD, 24'hFEDCBA, 24'h000001, 1'b1, 2'b01, 1'b1, 1'b0, "m01");
        repeat (70) @(negedge clk);
        send(24'hC0FFEE, 24'hBEEF01, 24'h111111, 24'h222222, 1'b0, 2'b10, 1'b0, 1'b0, "m10");
        repeat (70) @(negedge clk);
        send(24'h800001, 24'h7FFFFE, 24'h3C3C3C, 24'hC3C3C3, 1'b1, 2'b10, 1'b1, 1'b0, "m10w");
        repeat (70) @(negedge clk);
        send(24'hFF8000, 24'h00FFFF, 24'h55AAAA, 24'hAA5555, 1'b0, 2'b11, 1'b1, 1'b0, "m11");
        repeat (70) @(negedge clk);
        send(24'hFFFFFF, 24'h000000, 24'hABCDEF, 24'h0F1E2D, 1'b1, 2'b11, 1'b0, 1'b0, "m11w");
        repeat (70) @(negedge clk);

        // back-to-back: each next request (with new config) arrives mid-frame (R9 R10)
        send(24'h9A9A9A, 24'h6B6B6B, 24'h13579B, 24'h2468AC, 1'b1, 2'b11, 1'b1, 1'b0, "R10 first");
        send(24'h00F00F, 24'h0FF0F0, 24'h777777, 24'h888888, 1'b0, 2'b00, 1'b0, 1'b1, "R10 second");
        send(24'hDEAD01, 24'hBEEF02, 24'hCAFE03, 24'hF00D04, 1'b1, 2'b10, 1'b1, 1'b1, "R10 third");

        while (q.size() != 0 || in_frame) @(negedge clk);
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule